// File: doc/BRIEF.md
# Glitchless Dual-Ratio Clock Divider

This block divides a high-rate reference clock by an integer ratio to make one output clock. It holds two ratios, `ratio_a` and `ratio_b`, and chooses between them with a select level taken from one of two shared select lines. A per-channel mapping value binds the channel to line 0, to line 1, or to neither. Several channels on a chip can share one line, so a single pin can retune a whole group of outputs at once.

Each output period is a high phase of floor(N/2) reference cycles followed by a low phase of N - floor(N/2) cycles. A new ratio is taken only when a low phase ends. A change of selection therefore never cuts a pulse short: the period in flight completes at the old rate, and the first period at the new rate opens with a rising edge. The select lines are asynchronous to the reference and are passed through a two-flop synchroniser first. A build parameter gives a fixed-ratio variant that ignores the select lines and the mapping entirely.

Top module: `clkdiv_dual_ratio`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. This holds at once, even in the middle of a high phase. The first period after reset begins with a high phase of floor(N/2) reference cycles.
- R2: With ratio N in force, every output period is floor(N/2) reference cycles high followed by N - floor(N/2) cycles low. Odd ratios are included.
- R3: A selected ratio value of 0 or 1 is treated as 2.
- R4: A `sel_map` of 2'b00 or 2'b11 leaves the channel unbound: it uses `ratio_a` whatever the select lines carry.
- R5: A `sel_map` of 2'b01 binds the channel to `sel_line[0]`, and 2'b10 binds it to `sel_line[1]`. A bound line at 0 selects `ratio_a`, and at 1 selects `ratio_b`.
- R6: A new ratio is taken only at the end of a low phase. After a selection change, the period in progress completes at the old widths, and no high or low pulse is shorter than the smaller programmed half-period.
- R7: The first period at the new ratio starts with a rising edge. Its start comes no more than old N + new N reference cycles after the select line changes.
- R8: With parameter `SELECTABLE` = 0, the channel always divides by `ratio_a` (with the R3 floor applied), whatever `sel_map` and `sel_line` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_a | input | RW | Ratio used when the select level is 0 or the channel is unbound |
| ratio_b | input | RW | Ratio used when the bound select level is 1 |
| sel_map | input | 2 | Binding: 00/11 none, 01 line 0, 10 line 1 |
| sel_line | input | 2 | Shared select lines, asynchronous |
| clk_out | output | 1 | Divided clock, driven from a register |

## Verification
A change on `sel_line` passes through two synchroniser edges. It is then used at the next end of a low phase, and `clk_out` rises on that same edge, so the delay is a bound and not a fixed count. A change of ratio or mapping works the same way, without the synchroniser. The bench therefore samples `clk_out` one time unit after every falling edge and logs each pulse with its level, its width and its start cycle. Each check reads complete pulses from that log after a settling window longer than two periods. Switch checks record the cycle of the stimulus and compare the start of the first new-width high pulse against the old-plus-new period bound.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MAP_UNBOUND = 2'b00,
    MAP_LINE0   = 2'b01,
    MAP_LINE1   = 2'b10,
    MAP_UNUSED  = 2'b11
  } line_map_e;

  localparam int NUM_LINES = 2;
  localparam int MIN_RATIO = 2;
endpackage

// File: rtl/clkdiv_sync2.sv
module clkdiv_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        stab_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= async_in[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel
  import clkdiv_pkg::*;
#(
  parameter int RW         = 8,
  parameter bit SELECTABLE = 1'b1
) (
  input  logic [RW-1:0]        ratio_a,
  input  logic [RW-1:0]        ratio_b,
  input  logic [1:0]           sel_map,
  input  logic [NUM_LINES-1:0] lines_sync,
  output logic [RW-1:0]        ratio_next
);
  localparam logic [RW-1:0] FLOOR_N = RW'(MIN_RATIO);

  logic [RW-1:0] raw_n;

  if (SELECTABLE) begin : g_switch
    line_map_e map_e;
    logic      pick_b;
    always_comb begin
      map_e = line_map_e'(sel_map);
      case (map_e)
        MAP_LINE0: pick_b = lines_sync[0];
        MAP_LINE1: pick_b = lines_sync[1];
        default:   pick_b = 1'b0;
      endcase
      raw_n = pick_b ? ratio_b : ratio_a;
    end
  end else begin : g_fixed
    logic unused_sel;
    assign unused_sel = ^{ratio_b, sel_map, lines_sync};
    assign raw_n      = ratio_a;
  end

  assign ratio_next = (raw_n < FLOOR_N) ? FLOOR_N : raw_n;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_next,
  output logic          clk_div,
  output logic [RW-1:0] lat_n,
  output logic [RW-1:0] cnt,
  output logic          running,
  output logic          period_end
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] lat_q;
  logic          run_q;
  logic          out_q;
  logic [RW-1:0] cnt_nx;
  logic [RW-1:0] half_n;

  assign cnt_nx     = cnt_q + 1'b1;
  assign half_n     = lat_q >> 1;
  assign period_end = !run_q || (cnt_q == lat_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else if (period_end) begin
      cnt_q <= '0;
      lat_q <= ratio_next;
      run_q <= 1'b1;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nx;
      out_q <= (cnt_nx < half_n);
    end
  end

  assign clk_div = out_q;
  assign lat_n   = lat_q;
  assign cnt     = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/clkdiv_dual_ratio.sv
module clkdiv_dual_ratio
  import clkdiv_pkg::*;
#(
  parameter int RW         = 8,
  parameter bit SELECTABLE = 1'b1
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_a,
  input  logic [RW-1:0] ratio_b,
  input  logic [1:0]    sel_map,
  input  logic [1:0]    sel_line,
  output logic          clk_out
);
  logic [NUM_LINES-1:0] lines_sync;
  logic [RW-1:0]        ratio_next;
  logic [RW-1:0]        lat_n;
  logic [RW-1:0]        cnt_w;
  logic                 run_w;
  logic                 end_w;

  clkdiv_sync2 #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .async_in (sel_line),
    .sync_out (lines_sync)
  );

  clkdiv_ratio_sel #(.RW(RW), .SELECTABLE(SELECTABLE)) u_sel (
    .ratio_a    (ratio_a),
    .ratio_b    (ratio_b),
    .sel_map    (sel_map),
    .lines_sync (lines_sync),
    .ratio_next (ratio_next)
  );

  clkdiv_core #(.RW(RW)) u_core (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .ratio_next (ratio_next),
    .clk_div    (clk_out),
    .lat_n      (lat_n),
    .cnt        (cnt_w),
    .running    (run_w),
    .period_end (end_w)
  );
endmodule

// File: rtl/clkdiv_dual_ratio_chk.sv
module clkdiv_dual_ratio_chk #(
  parameter int RW = 8
) (
  input logic          clk_ref,
  input logic          rst_n,
  input logic          clk_out,
  input logic [RW-1:0] lat_n,
  input logic [RW-1:0] cnt,
  input logic          run,
  input logic          period_end
);
  p_reset_low_r1: assert property (@(posedge clk_ref)
    !rst_n |=> !clk_out);

  p_count_in_range_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    run |-> (cnt < lat_n));

  p_ratio_floor_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    run |-> (lat_n >= RW'(2)));

  p_latch_at_boundary_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (lat_n != $past(lat_n)) |-> $past(period_end));

  p_rise_at_boundary_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_out) |-> $past(period_end));
endmodule

bind clkdiv_dual_ratio clkdiv_dual_ratio_chk #(.RW(RW)) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .clk_out    (clk_out),
  .lat_n      (lat_n),
  .cnt        (cnt_w),
  .run        (run_w),
  .period_end (end_w)
);

// File: tb/clkdiv_dual_ratio_tb_top.sv
module clkdiv_dual_ratio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RW         = 8;
  localparam int HIST       = 2048;
  localparam int NVEC       = 10;

  // columns: ratio_a, ratio_b, sel_map, sel_line, high, low, requirement
  localparam int VEC [NVEC][7] = '{
    '{4, 9, 0, 3, 2, 2, 4},   // R4 unbound ignores lines
    '{5, 9, 3, 3, 2, 3, 4},   // R4 map 11 unbound, odd ratio
    '{4, 9, 1, 1, 4, 5, 5},   // R5 line0 high -> b
    '{4, 9, 1, 2, 2, 2, 5},   // R5 line0 low -> a
    '{4, 9, 2, 2, 4, 5, 5},   // R5 line1 high -> b
    '{4, 9, 2, 1, 2, 2, 5},   // R5 line1 low -> a
    '{1, 7, 0, 0, 1, 1, 3},   // R3 ratio 1 floored
    '{6, 0, 1, 1, 1, 1, 3},   // R3 ratio 0 floored
    '{13, 3, 2, 3, 1, 2, 2},  // R2 odd ratio 3
    '{2, 12, 1, 0, 1, 1, 2}   // R2 minimum ratio
  };

  logic          clk_ref = 1'b0;
  logic          rst_n;
  logic [RW-1:0] ratio_a, ratio_b;
  logic [1:0]    sel_map, sel_line;
  logic          clk_out, clk_fix;

  int checks = 0, errors = 0, cyc = 0, mon_min = 0;
  bit done = 1'b0;
  int   rec_len [HIST];
  logic rec_lvl [HIST];
  int   rec_start [HIST];
  int   nrec = 0;
  logic cur_lvl = 1'b0;
  int   run_len = 0, run_start = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  clkdiv_dual_ratio #(.RW(RW), .SELECTABLE(1'b1)) dut_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .sel_map(sel_map), .sel_line(sel_line), .clk_out(clk_out));

  clkdiv_dual_ratio #(.RW(RW), .SELECTABLE(1'b0)) dut_fix_i (
    .clk_ref(clk_ref), .rst_n(rst_n), .ratio_a(ratio_a), .ratio_b(ratio_b),
    .sel_map(sel_map), .sel_line(sel_line), .clk_out(clk_fix));

  // pulse log, sampled away from the rising edge
  always @(negedge clk_ref) begin
    cyc++;
    if (rst_n !== 1'b1) begin
      cur_lvl   = 1'b0;
      run_len   = 0;
      run_start = cyc;
    end else if (clk_out === cur_lvl) begin
      run_len++;
    end else begin
      if (run_len > 0 && nrec < HIST) begin
        rec_len[nrec]   = run_len;
        rec_lvl[nrec]   = cur_lvl;
        rec_start[nrec] = run_start;
        nrec++;
        if (mon_min > 0) begin
          checks++;
          if (run_len < mon_min) begin
            errors++;
            $display("FAIL R6 runt pulse: actual %0d expected >= %0d", run_len, mon_min);
          end
        end
      end
      cur_lvl   = clk_out;
      run_len   = 1;
      run_start = cyc;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_ref);
      #1;
    end
  endtask

  task automatic wait_rise();
    logic p;
    tick(1);
    p = clk_out;
    forever begin
      tick(1);
      if (clk_out && !p) break;
      p = clk_out;
    end
  endtask

  task automatic fix_period(output int per);
    logic p;
    int t0;
    tick(1);
    p = clk_fix;
    forever begin tick(1); if (clk_fix && !p) break; p = clk_fix; end
    t0 = cyc;
    p = clk_fix;
    forever begin tick(1); if (clk_fix && !p) break; p = clk_fix; end
    per = cyc - t0;
  endtask

  task automatic first_period(input int from, output int hi, output int lo);
    hi = -1;
    lo = -1;
    for (int k = from; k + 1 < nrec; k++) begin
      if (rec_lvl[k] == 1'b1) begin
        hi = rec_len[k];
        lo = rec_len[k+1];
        break;
      end
    end
  endtask

  // R6/R7: old widths until the first new-width high pulse, bounded start
  task automatic check_switch(int idx0, int t0, int oh, int ol, int nh, int bound);
    int j = -1;
    for (int k = idx0; k < nrec; k++) begin
      if (rec_lvl[k] == 1'b1 && rec_len[k] == nh) begin j = k; break; end
      chk("R6", "old-rate pulse width", rec_len[k], rec_lvl[k] ? oh : ol);
    end
    chk("R7", "new-rate high pulse found", (j >= 0) ? 1 : 0, 1);
    if (j > idx0) begin
      chk("R7", "new period preceded by full low", rec_len[j-1], ol);
      checks++;
      if (rec_start[j] - t0 > bound) begin
        errors++;
        $display("FAIL R7 switch latency: actual %0d expected <= %0d", rec_start[j] - t0, bound);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, idx0, t0, per;
    rst_n    = 1'b0;
    ratio_a  = 8'd4;
    ratio_b  = 8'd9;
    sel_map  = 2'b00;
    sel_line = 2'b00;
    tick(4);
    chk("R1", "clk_out in reset", int'(clk_out), 0);
    chk("R8", "fixed clk_out in reset", int'(clk_fix), 0);
    idx0  = nrec;
    rst_n = 1'b1;
    tick(30);
    first_period(idx0, hi, lo);
    chk("R1", "first high after reset", hi, 2);

    // table walk (R2 R3 R4 R5)
    for (int v = 0; v < NVEC; v++) begin
      ratio_a  = RW'(VEC[v][0]);
      ratio_b  = RW'(VEC[v][1]);
      sel_map  = 2'(VEC[v][2]);
      sel_line = 2'(VEC[v][3]);
      tick(60);
      idx0 = nrec;
      tick(40);
      first_period(idx0, hi, lo);
      chk($sformatf("R%0d", VEC[v][6]), $sformatf("vec %0d high", v), hi, VEC[v][4]);
      chk($sformatf("R%0d", VEC[v][6]), $sformatf("vec %0d low", v), lo, VEC[v][5]);
    end

    // R8: fixed variant ignores mapping and lines
    ratio_a = 8'd4; ratio_b = 8'd9; sel_map = 2'b01; sel_line = 2'b01;
    tick(30);
    fix_period(per);
    chk("R8", "fixed period with line0 bound high", per, 4);
    ratio_a = 8'd7; sel_map = 2'b10; sel_line = 2'b10;
    tick(30);
    fix_period(per);
    chk("R8", "fixed period with line1 bound high", per, 7);
    ratio_a = 8'd1;
    tick(30);
    fix_period(per);
    chk("R8", "fixed period floored", per, 2);

    // R6 R7: switch a(6) -> b(10) during a high phase
    ratio_a = 8'd6; ratio_b = 8'd10; sel_map = 2'b01; sel_line = 2'b00;
    tick(60);
    mon_min = 3;
    wait_rise();
    tick(1);
    t0 = cyc; idx0 = nrec;
    sel_line = 2'b01;
    tick(60);
    check_switch(idx0, t0, 3, 3, 5, 16);

    // R6 R7: switch b(10) -> a(6) during a low phase
    wait_rise();
    tick(7);
    t0 = cyc; idx0 = nrec;
    sel_line = 2'b00;
    tick(60);
    check_switch(idx0, t0, 5, 5, 3, 16);

    // R6: ratio change mid-period on bound-off channel
    wait_rise();
    tick(1);
    idx0 = nrec;
    ratio_a = 8'd8;
    tick(60);
    check_switch(idx0, cyc - 60, 3, 3, 4, 60);
    mon_min = 0;

    // R1: reset during a high phase forces low at once
    wait_rise();
    rst_n = 1'b0;
    #1;
    chk("R1", "clk_out on mid-high reset", int'(clk_out), 0);
    tick(3);
    chk("R1", "clk_out held in reset", int'(clk_out), 0);
    idx0  = nrec;
    rst_n = 1'b1;
    tick(30);
    first_period(idx0, hi, lo);
    chk("R1", "first high after second reset", hi, 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule